// File: doc/BRIEF.md
# Partial Forward Stall Controller

This block sits beside a load-store queue and owns the stall that arises when an issued load finds an older store that covers only part of the bytes the load needs. Such a load cannot take forwarded data and cannot go to the cache yet. The block sends it back to the issue logic for replay, which also clears its issued status and means it writes back no result. It keeps one record of the oldest load stalled this way, plus the store it waits on. When that store reports writeback completion, the stall drops and one release pulse names the recorded load so it can be replayed again.

The same block gates strictly ordered loads. Such a load may go ahead only when it is the load-queue head and is also ready to commit. Any other strictly ordered load is returned for replay. A pipeline squash that reaches the recorded load removes the stall state without a release. Sequence numbers are plain unsigned values of fixed width, compared without wraparound.

Top module: `pfs_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `stall`, `go_valid`, `ord_replay_valid`, `ovl_replay_valid` and `rel_valid` are all 0.
- R2: An issued load with `iss_strict`=1 that lacks `iss_at_head` or `iss_at_commit` gives `ord_replay_valid`=1 with its index one cycle later, and `go_valid` stays 0.
- R3: An issued load with `iss_strict`=0, or with `iss_strict`=1 and both `iss_at_head` and `iss_at_commit` set, gives `go_valid`=1 with its index one cycle later and no replay.
- R4: A partial-overlap event while no stall is held sets `stall` one cycle later and records the store sequence, the load index and the load sequence on `stall_st_seq`, `stall_ld_idx`, `stall_ld_seq`.
- R5: A partial-overlap event while a stall is held replaces the record only when its load sequence is strictly smaller than the recorded one; an equal or larger sequence leaves the record unchanged.
- R6: Every partial-overlap event, whether recorded or not, gives `ovl_replay_valid`=1 with its load index one cycle later; this pulse means the load's issued status is cleared and it produces no writeback result.
- R7: A writeback-complete event whose store sequence equals `stall_st_seq` while stalled clears `stall` and gives one `rel_valid` pulse carrying the recorded load index one cycle later; a non-matching store sequence has no effect.
- R8: A squash with `sq_seq` at or below `stall_ld_seq` clears `stall` with no release pulse, and takes priority over a matching writeback in the same cycle; a squash above it has no effect.
- R9: When a releasing writeback and a partial-overlap event fall in the same cycle, the old load is released and the new event is recorded, whatever its sequence.
- R10: A partial-overlap event in the same cycle as a squash is not recorded when its load sequence is at or above `sq_seq`, but still gives its replay pulse.
- R11: Sequence comparison is unsigned: sequence 0 counts as older than the all-ones sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | A load is being issued |
| iss_idx | input | IDX_W | Load-queue index of the issued load |
| iss_at_head | input | 1 | Issued load is the load-queue head |
| iss_at_commit | input | 1 | Issued load is ready to commit |
| iss_strict | input | 1 | Issued load is strictly ordered |
| ovl_valid | input | 1 | Forwarding lookup found a partial overlap |
| ovl_idx | input | IDX_W | Load-queue index of the overlapping load |
| ovl_seq | input | SEQ_W | Sequence number of the overlapping load |
| ovl_st_seq | input | SEQ_W | Sequence number of the partially covering store |
| wb_valid | input | 1 | A store finished writeback |
| wb_st_seq | input | SEQ_W | Sequence number of that store |
| sq_valid | input | 1 | Squash of all instructions at or after `sq_seq` |
| sq_seq | input | SEQ_W | Oldest squashed sequence number |
| go_valid | output | 1 | Issued load may proceed |
| go_idx | output | IDX_W | Index of the proceeding load |
| ord_replay_valid | output | 1 | Strictly ordered load sent back for replay |
| ord_replay_idx | output | IDX_W | Index of that load |
| ovl_replay_valid | output | 1 | Overlapping load sent back, issued status cleared, no result |
| ovl_replay_idx | output | IDX_W | Index of that load |
| stall | output | 1 | A partial-overlap stall is held |
| stall_st_seq | output | SEQ_W | Store the stall waits on |
| stall_ld_idx | output | IDX_W | Index of the recorded load |
| stall_ld_seq | output | SEQ_W | Sequence of the recorded load |
| rel_valid | output | 1 | Release pulse for the recorded load |
| rel_idx | output | IDX_W | Index of the released load |

## Verification
The writeback that ends a stall and a fresh partial-overlap event can land in the same cycle, and so can a squash and an overlap event. The bench builds a stall, then drives the matching writeback together with an overlap carrying a larger load sequence, and judges that the release names the old load while the record switches to the new one, followed by a second writeback that releases the new one. It also pairs a squash with overlap events above and below the squash point and checks which one is recorded while both receive a replay.

// File: rtl/pfs_pkg.sv
// Package: shared decision type for the partial forward stall controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pfs_pkg;

    // Action the stall record takes at the next clock edge.
    typedef enum logic [1:0] {
        TRK_HOLD    = 2'd0,
        TRK_CAPTURE = 2'd1,
        TRK_CLEAR   = 2'd2
    } trk_act_e;

endpackage

// File: rtl/pfs_pulse_reg.sv
// Module: pfs_pulse_reg
// Registers a one-cycle valid pulse together with a payload; the payload
// keeps its last value while valid is low.
// Assumes: synchronous active-low reset, payload width W >= 1.
module pfs_pulse_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    // Capture the pulse and its payload for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/pfs_order_gate.sv
// Module: pfs_order_gate
// Decides for each issued load whether it proceeds or is sent back because
// it is strictly ordered and not both at the load-queue head and at commit.
// Assumes: at most one load issued per cycle; results appear one cycle later.
module pfs_order_gate #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_idx,
    input  logic             iss_at_head,
    input  logic             iss_at_commit,
    input  logic             iss_strict,
    output logic             go_valid,
    output logic [IDX_W-1:0] go_idx,
    output logic             back_valid,
    output logic [IDX_W-1:0] back_idx
);

    logic may_go;
    logic go_now;
    logic back_now;

    // An ordered load passes only at the head and with commit readiness.
    always_comb begin
        may_go   = !iss_strict || (iss_at_head && iss_at_commit);
        go_now   = iss_valid && may_go;
        back_now = iss_valid && !may_go;
    end

    pfs_pulse_reg #(.W(IDX_W)) u_go_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (go_now),
        .in_data   (iss_idx),
        .out_valid (go_valid),
        .out_data  (go_idx)
    );

    pfs_pulse_reg #(.W(IDX_W)) u_back_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (back_now),
        .in_data   (iss_idx),
        .out_valid (back_valid),
        .out_data  (back_idx)
    );

endmodule

// File: rtl/pfs_stall_track.sv
// Module: pfs_stall_track
// Holds the single stall record (store sequence, load index, load sequence)
// for the oldest load that met a partially covering store, and decides
// capture, replacement, release and squash clearing each cycle.
// Assumes: sequence numbers are unsigned with no wraparound; a squash
// removes every instruction whose sequence is at or above sq_seq.
module pfs_stall_track
    import pfs_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovl_valid,
    input  logic [IDX_W-1:0] ovl_idx,
    input  logic [SEQ_W-1:0] ovl_seq,
    input  logic [SEQ_W-1:0] ovl_st_seq,
    input  logic             wb_valid,
    input  logic [SEQ_W-1:0] wb_st_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             stall,
    output logic [SEQ_W-1:0] st_seq,
    output logic [IDX_W-1:0] ld_idx,
    output logic [SEQ_W-1:0] ld_seq,
    output logic             rel_fire,
    output logic [IDX_W-1:0] rel_load
);

    logic     sq_hit;
    logic     wb_hit;
    logic     held;
    logic     cap_ok;
    logic     take;
    trk_act_e act;

    // Classify this cycle's events against the current record.
    always_comb begin
        sq_hit = sq_valid && stall && (sq_seq <= ld_seq);
        wb_hit = wb_valid && stall && !sq_hit && (wb_st_seq == st_seq);
        held   = stall && !sq_hit && !wb_hit;
        cap_ok = ovl_valid && !(sq_valid && (ovl_seq >= sq_seq));
        take   = cap_ok && (!held || (ovl_seq < ld_seq));
        if (take) begin
            act = TRK_CAPTURE;
        end else if (!held) begin
            act = TRK_CLEAR;
        end else begin
            act = TRK_HOLD;
        end
        rel_fire = wb_hit;
        rel_load = ld_idx;
    end

    // Update the stall record according to the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall  <= 1'b0;
            st_seq <= '0;
            ld_idx <= '0;
            ld_seq <= '0;
        end else begin
            case (act)
                TRK_CAPTURE: begin
                    stall  <= 1'b1;
                    st_seq <= ovl_st_seq;
                    ld_idx <= ovl_idx;
                    ld_seq <= ovl_seq;
                end
                TRK_CLEAR: begin
                    stall <= 1'b0;
                end
                default: begin
                    stall <= stall;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfs_ctrl.sv
// Module: pfs_ctrl (top)
// Partial forward stall controller: gates strictly ordered loads, replays
// loads that met a partially covering store, keeps the oldest such load as
// the stall record and releases it when its store finishes writeback.
// Assumes: one issue, one overlap, one writeback and one squash event at
// most per cycle; every output is registered (one cycle after its cause).
module pfs_ctrl #(
    parameter int LQ_DEPTH = 32,
    parameter int SEQ_W    = 16,
    localparam int IDX_W   = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_idx,
    input  logic             iss_at_head,
    input  logic             iss_at_commit,
    input  logic             iss_strict,
    input  logic             ovl_valid,
    input  logic [IDX_W-1:0] ovl_idx,
    input  logic [SEQ_W-1:0] ovl_seq,
    input  logic [SEQ_W-1:0] ovl_st_seq,
    input  logic             wb_valid,
    input  logic [SEQ_W-1:0] wb_st_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             go_valid,
    output logic [IDX_W-1:0] go_idx,
    output logic             ord_replay_valid,
    output logic [IDX_W-1:0] ord_replay_idx,
    output logic             ovl_replay_valid,
    output logic [IDX_W-1:0] ovl_replay_idx,
    output logic             stall,
    output logic [SEQ_W-1:0] stall_st_seq,
    output logic [IDX_W-1:0] stall_ld_idx,
    output logic [SEQ_W-1:0] stall_ld_seq,
    output logic             rel_valid,
    output logic [IDX_W-1:0] rel_idx
);

    logic             rel_fire;
    logic [IDX_W-1:0] rel_load;

    pfs_order_gate #(.IDX_W(IDX_W)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .iss_valid     (iss_valid),
        .iss_idx       (iss_idx),
        .iss_at_head   (iss_at_head),
        .iss_at_commit (iss_at_commit),
        .iss_strict    (iss_strict),
        .go_valid      (go_valid),
        .go_idx        (go_idx),
        .back_valid    (ord_replay_valid),
        .back_idx      (ord_replay_idx)
    );

    pfs_stall_track #(.IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovl_valid  (ovl_valid),
        .ovl_idx    (ovl_idx),
        .ovl_seq    (ovl_seq),
        .ovl_st_seq (ovl_st_seq),
        .wb_valid   (wb_valid),
        .wb_st_seq  (wb_st_seq),
        .sq_valid   (sq_valid),
        .sq_seq     (sq_seq),
        .stall      (stall),
        .st_seq     (stall_st_seq),
        .ld_idx     (stall_ld_idx),
        .ld_seq     (stall_ld_seq),
        .rel_fire   (rel_fire),
        .rel_load   (rel_load)
    );

    // Every overlapping load is returned, recorded or not.
    pfs_pulse_reg #(.W(IDX_W)) u_ovl_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ovl_valid),
        .in_data   (ovl_idx),
        .out_valid (ovl_replay_valid),
        .out_data  (ovl_replay_idx)
    );

    // Release pulse for the recorded load once its store is written back.
    pfs_pulse_reg #(.W(IDX_W)) u_rel_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rel_fire),
        .in_data   (rel_load),
        .out_valid (rel_valid),
        .out_data  (rel_idx)
    );

endmodule

// File: rtl/pfs_ctrl_chk.sv
// Module: pfs_ctrl_chk
// Temporal checks on the ports of pfs_ctrl, attached with bind below.
// Assumes: synchronous active-low reset drives all inputs low while active.
module pfs_ctrl_chk #(
    parameter int IDX_W = 5,
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ovl_valid,
    input logic [IDX_W-1:0] ovl_idx,
    input logic             wb_valid,
    input logic             sq_valid,
    input logic             go_valid,
    input logic             ord_replay_valid,
    input logic             ovl_replay_valid,
    input logic [IDX_W-1:0] ovl_replay_idx,
    input logic             stall,
    input logic [SEQ_W-1:0] stall_ld_seq,
    input logic             rel_valid
);

    // R2
    go_or_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_valid && ord_replay_valid));

    // R4
    stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(ovl_valid));

    // R5
    older_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall) && !rel_valid && (stall_ld_seq != $past(stall_ld_seq)))
        |-> (stall_ld_seq < $past(stall_ld_seq)));

    // R6
    ovl_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_replay_valid |-> ($past(ovl_valid) && (ovl_replay_idx == $past(ovl_idx))));

    // R7
    release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> ($past(stall) && $past(wb_valid)));

    // R8
    stall_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> ($past(wb_valid) || $past(sq_valid)));

endmodule

bind pfs_ctrl pfs_ctrl_chk #(.IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .ovl_valid        (ovl_valid),
    .ovl_idx          (ovl_idx),
    .wb_valid         (wb_valid),
    .sq_valid         (sq_valid),
    .go_valid         (go_valid),
    .ord_replay_valid (ord_replay_valid),
    .ovl_replay_valid (ovl_replay_valid),
    .ovl_replay_idx   (ovl_replay_idx),
    .stall            (stall),
    .stall_ld_seq     (stall_ld_seq),
    .rel_valid        (rel_valid)
);

// File: tb/pfs_ctrl_test.sv
// Directed bench for pfs_ctrl: inputs change at falling edges, outputs are
// read at the falling edge after the rising edge that registers them.
module pfs_ctrl_test;

    localparam int LQ_DEPTH = 32;
    localparam int SEQ_W    = 16;
    localparam int IDX_W    = $clog2(LQ_DEPTH);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             iss_valid, iss_at_head, iss_at_commit, iss_strict;
    logic [IDX_W-1:0] iss_idx;
    logic             ovl_valid;
    logic [IDX_W-1:0] ovl_idx;
    logic [SEQ_W-1:0] ovl_seq, ovl_st_seq;
    logic             wb_valid;
    logic [SEQ_W-1:0] wb_st_seq;
    logic             sq_valid;
    logic [SEQ_W-1:0] sq_seq;
    logic             go_valid, ord_replay_valid, ovl_replay_valid, stall, rel_valid;
    logic [IDX_W-1:0] go_idx, ord_replay_idx, ovl_replay_idx, stall_ld_idx, rel_idx;
    logic [SEQ_W-1:0] stall_st_seq, stall_ld_seq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pfs_ctrl #(.LQ_DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_at_head(iss_at_head),
        .iss_at_commit(iss_at_commit), .iss_strict(iss_strict),
        .ovl_valid(ovl_valid), .ovl_idx(ovl_idx), .ovl_seq(ovl_seq), .ovl_st_seq(ovl_st_seq),
        .wb_valid(wb_valid), .wb_st_seq(wb_st_seq), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .go_valid(go_valid), .go_idx(go_idx),
        .ord_replay_valid(ord_replay_valid), .ord_replay_idx(ord_replay_idx),
        .ovl_replay_valid(ovl_replay_valid), .ovl_replay_idx(ovl_replay_idx),
        .stall(stall), .stall_st_seq(stall_st_seq), .stall_ld_idx(stall_ld_idx),
        .stall_ld_seq(stall_ld_seq), .rel_valid(rel_valid), .rel_idx(rel_idx)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic idle();
        iss_valid = 0; iss_idx = '0; iss_at_head = 0; iss_at_commit = 0; iss_strict = 0;
        ovl_valid = 0; ovl_idx = '0; ovl_seq = '0; ovl_st_seq = '0;
        wb_valid = 0; wb_st_seq = '0; sq_valid = 0; sq_seq = '0;
    endtask

    // One rising edge, then back to a falling edge where outputs are read.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ovl(input int idx, input int seq, input int st);
        ovl_valid = 1; ovl_idx = IDX_W'(idx); ovl_seq = SEQ_W'(seq); ovl_st_seq = SEQ_W'(st);
    endtask

    task automatic expect_rec(input string req, input int st, input int idx, input int seq);
        chk_eq({req, " stall"}, stall, 1);
        chk_eq({req, " st_seq"}, stall_st_seq, st);
        chk_eq({req, " ld_idx"}, stall_ld_idx, idx);
        chk_eq({req, " ld_seq"}, stall_ld_seq, seq);
    endtask

    task automatic t_reset();
        chk_eq("R1 stall", stall, 0);
        chk_eq("R1 go", go_valid, 0);
        chk_eq("R1 ord_replay", ord_replay_valid, 0);
        chk_eq("R1 ovl_replay", ovl_replay_valid, 0);
        chk_eq("R1 rel", rel_valid, 0);
    endtask

    task automatic t_order();
        // R2: strict at head, not at commit
        iss_valid = 1; iss_idx = 5'd9; iss_strict = 1; iss_at_head = 1; iss_at_commit = 0;
        step(); idle();
        chk_eq("R2 back head-only", ord_replay_valid, 1);
        chk_eq("R2 back idx", ord_replay_idx, 9);
        chk_eq("R2 no go", go_valid, 0);
        // R2: strict at commit, not at head
        iss_valid = 1; iss_idx = 5'd4; iss_strict = 1; iss_at_head = 0; iss_at_commit = 1;
        step(); idle();
        chk_eq("R2 back commit-only", ord_replay_valid, 1);
        chk_eq("R2 no go 2", go_valid, 0);
        // R3: strict with both
        iss_valid = 1; iss_idx = 5'd11; iss_strict = 1; iss_at_head = 1; iss_at_commit = 1;
        step(); idle();
        chk_eq("R3 strict go", go_valid, 1);
        chk_eq("R3 go idx", go_idx, 11);
        chk_eq("R3 no back", ord_replay_valid, 0);
        // R3: ordinary load anywhere
        iss_valid = 1; iss_idx = 5'd30; iss_strict = 0;
        step(); idle();
        chk_eq("R3 plain go", go_valid, 1);
        chk_eq("R3 plain idx", go_idx, 30);
        step();
        chk_eq("R3 pulse ends", go_valid, 0);
    endtask

    task automatic t_capture_replace();
        ovl(5, 100, 90); step(); idle();
        expect_rec("R4 capture", 90, 5, 100);
        chk_eq("R6 replay", ovl_replay_valid, 1);
        chk_eq("R6 replay idx", ovl_replay_idx, 5);
        ovl(6, 120, 95); step(); idle();
        expect_rec("R5 younger kept", 90, 5, 100);
        chk_eq("R6 replay younger", ovl_replay_valid, 1);
        chk_eq("R6 replay younger idx", ovl_replay_idx, 6);
        ovl(3, 80, 70); step(); idle();
        expect_rec("R5 older replaces", 70, 3, 80);
        ovl(7, 80, 60); step(); idle();
        expect_rec("R5 equal kept", 70, 3, 80);
        step();
        chk_eq("R6 replay ends", ovl_replay_valid, 0);
    endtask

    task automatic t_release();
        wb_valid = 1; wb_st_seq = 16'd90; step(); idle();
        expect_rec("R7 other store ignored", 70, 3, 80);
        chk_eq("R7 no rel", rel_valid, 0);
        wb_valid = 1; wb_st_seq = 16'd70; step(); idle();
        chk_eq("R7 stall cleared", stall, 0);
        chk_eq("R7 rel", rel_valid, 1);
        chk_eq("R7 rel idx", rel_idx, 3);
        step();
        chk_eq("R7 single pulse", rel_valid, 0);
    endtask

    task automatic t_squash();
        ovl(2, 50, 40); step(); idle();
        expect_rec("R8 setup", 40, 2, 50);
        sq_valid = 1; sq_seq = 16'd60; step(); idle();
        expect_rec("R8 younger squash ignored", 40, 2, 50);
        sq_valid = 1; sq_seq = 16'd50; wb_valid = 1; wb_st_seq = 16'd40; step(); idle();
        chk_eq("R8 squash clears", stall, 0);
        chk_eq("R8 no rel", rel_valid, 0);
    endtask

    task automatic t_collide();
        ovl(1, 30, 20); step(); idle();
        expect_rec("R9 setup", 20, 1, 30);
        wb_valid = 1; wb_st_seq = 16'd20; ovl(4, 40, 35); step(); idle();
        chk_eq("R9 old released", rel_valid, 1);
        chk_eq("R9 old idx", rel_idx, 1);
        expect_rec("R9 new recorded", 35, 4, 40);
        wb_valid = 1; wb_st_seq = 16'd35; step(); idle();
        chk_eq("R9 second rel", rel_valid, 1);
        chk_eq("R9 second idx", rel_idx, 4);
        chk_eq("R9 stall off", stall, 0);
    endtask

    task automatic t_squash_ovl();
        sq_valid = 1; sq_seq = 16'd10; ovl(8, 12, 9); step(); idle();
        chk_eq("R10 squashed not recorded", stall, 0);
        chk_eq("R10 replay still", ovl_replay_valid, 1);
        sq_valid = 1; sq_seq = 16'd10; ovl(9, 5, 2); step(); idle();
        expect_rec("R10 older recorded", 2, 9, 5);
        sq_valid = 1; sq_seq = 16'd5; step(); idle();
        chk_eq("R10 cleanup", stall, 0);
    endtask

    task automatic t_wrap();
        ovl(12, 16'hFFFF, 3); step(); idle();
        expect_rec("R11 all-ones", 3, 12, 16'hFFFF);
        ovl(13, 0, 1); step(); idle();
        expect_rec("R11 zero older", 1, 13, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_order();
        t_capture_replace();
        t_release();
        t_squash();
        t_collide();
        t_squash_ovl();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule